// File: doc/BRIEF.md
# Burst Address Generator with Recall

This block produces the memory address for every clock cycle of a synchronous memory port. On each rising edge it does one of four things: it takes a new address from outside, steps an internal counter by one, keeps the address it already has, or jumps back to a saved recall address. The recall address is the most recent address taken from outside. It lets a caller run the same burst again without sending the start address a second time.

Three active-low strobes control the block: load, count enable and recall. The block does not look at memory selects or byte enables, so it keeps counting, loading and recalling while the memory is idle. Besides the address, it outputs a flag that shows whether the recall register has been loaded since reset. The recall register itself has no reset value. A recall before the first load therefore gives an address that is not defined.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low, addr_o is 0 and rpt_valid_o is 0, and both take these values at once, without waiting for a clock edge.
- R2: On an edge where rpt_ni is 1 and load_ni is 0, addr_o takes the value of ext_addr_i after that edge.
- R3: On an edge where rpt_ni and load_ni are 1 and cnt_en_ni is 0, addr_o becomes its previous value plus one. The value 2^ADDR_W-1 (0x7FFFF by default) wraps to 0.
- R4: On an edge where rpt_ni, load_ni and cnt_en_ni are all 1, addr_o keeps its value, whatever ext_addr_i is.
- R5: On an edge where rpt_ni is 0 and rpt_valid_o is 1, addr_o becomes the address of the last effective load, whatever load_ni and cnt_en_ni are.
- R6: Recall has the highest priority. A load requested on the same edge as a recall has no effect: it neither changes the recall register nor sets rpt_valid_o. A recall while rpt_valid_o is 0 leaves rpt_valid_o at 0.
- R7: Every effective load (R2) writes ext_addr_i into the recall register and sets rpt_valid_o. Only reset clears rpt_valid_o.
- R8: The block ignores the strobes on the first two rising edges after rst_ni rises. It acts on them from the third edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Active-low reset: asserts asynchronously, released in step with the clock |
| ext_addr_i | input | 19 | Address supplied from outside |
| load_ni | input | 1 | Active-low load strobe |
| cnt_en_ni | input | 1 | Active-low count enable |
| rpt_ni | input | 1 | Active-low recall strobe |
| addr_o | output | 19 | Address used this cycle |
| rpt_valid_o | output | 1 | Recall register holds a loaded address |

## Verification
A recall and a load can fall on the same edge, and only the recall may act. The bench provokes this in two ways. A directed step asserts both strobes together with a fresh address, and a random phase lets them coincide often. A behavioural model works out the outcome, and a later recall, with no load in between, shows whether the recall register still holds the older address. Each cycle, the model's address and flag are compared with the outputs. The address comparison is skipped only while the model marks it undefined after an early recall.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD   = 2'd0,
    OP_COUNT  = 2'd1,
    OP_LOAD   = 2'd2,
    OP_RECALL = 2'd3
  } burst_op_e;
endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/burst_op_decode.sv
module burst_op_decode
  import burst_addr_pkg::*;
(
  input  logic      load_ni,
  input  logic      cnt_en_ni,
  input  logic      rpt_ni,
  output burst_op_e op_o
);
  // Priority: recall, then load, then count, then hold
  always_comb begin
    if (!rpt_ni) begin
      op_o = OP_RECALL;
    end else if (!load_ni) begin
      op_o = OP_LOAD;
    end else if (!cnt_en_ni) begin
      op_o = OP_COUNT;
    end else begin
      op_o = OP_HOLD;
    end
  end
endmodule

// File: rtl/burst_repeat_store.sv
module burst_repeat_store #(
  parameter int ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] rpt_addr_o,
  output logic              rpt_valid_o
);
  logic [ADDR_W-1:0] rpt_addr_q;
  logic              rpt_valid_q;
  logic              rpt_valid_d;

  always_comb begin
    rpt_valid_d = rpt_valid_q | capture_i;
  end

  // Data register without reset, written only when a load is captured
  always_ff @(posedge clk_i) begin
    if (capture_i) begin
      rpt_addr_q <= addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rpt_valid_q <= 1'b0;
    end else begin
      rpt_valid_q <= rpt_valid_d;
    end
  end

  assign rpt_addr_o  = rpt_addr_q;
  assign rpt_valid_o = rpt_valid_q;
endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  burst_op_e         op_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  input  logic [ADDR_W-1:0] rpt_addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;

  always_comb begin
    addr_en = 1'b1;
    addr_d  = addr_q;
    unique case (op_i)
      OP_RECALL: addr_d = rpt_addr_i;
      OP_LOAD:   addr_d = ext_addr_i;
      OP_COUNT:  addr_d = addr_q + ONE;
      default:   addr_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] ext_addr_i,
  input  logic              load_ni,
  input  logic              cnt_en_ni,
  input  logic              rpt_ni,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rpt_valid_o
);
  logic              rst_sync_n;
  burst_op_e         op;
  logic              capture;
  logic [ADDR_W-1:0] rpt_addr;

  burst_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  burst_op_decode u_decode (
    .load_ni  (load_ni),
    .cnt_en_ni(cnt_en_ni),
    .rpt_ni   (rpt_ni),
    .op_o     (op)
  );

  assign capture = (op == OP_LOAD);

  burst_repeat_store #(.ADDR_W(ADDR_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .capture_i  (capture),
    .addr_i     (ext_addr_i),
    .rpt_addr_o (rpt_addr),
    .rpt_valid_o(rpt_valid_o)
  );

  burst_addr_counter #(.ADDR_W(ADDR_W)) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .op_i      (op),
    .ext_addr_i(ext_addr_i),
    .rpt_addr_i(rpt_addr),
    .addr_o    (addr_o)
  );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic [ADDR_W-1:0] ext_addr_i,
  input logic              load_ni,
  input logic              cnt_en_ni,
  input logic              rpt_ni,
  input logic [ADDR_W-1:0] addr_o,
  input logic              rpt_valid_o
);
  logic [ADDR_W-1:0] shadow_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (rpt_ni && !load_ni) begin
      shadow_q <= ext_addr_i;
    end
  end

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rpt_ni && !load_ni) |=> (addr_o == $past(ext_addr_i)));

  assert_count_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rpt_ni && load_ni && !cnt_en_ni) |=> (addr_o == ADDR_W'($past(addr_o) + 1'b1)));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rpt_ni && load_ni && cnt_en_ni) |=> $stable(addr_o));

  assert_recall_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!rpt_ni && rpt_valid_o) |=> (addr_o == shadow_q));

  assert_early_recall_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!rpt_ni && !rpt_valid_o) |=> !rpt_valid_o);

  assert_flag_set_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rpt_ni && !load_ni) |=> rpt_valid_o);

  assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$fell(rpt_valid_o));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_sync_n),
  .ext_addr_i (ext_addr_i),
  .load_ni    (load_ni),
  .cnt_en_ni  (cnt_en_ni),
  .rpt_ni     (rpt_ni),
  .addr_o     (addr_o),
  .rpt_valid_o(rpt_valid_o)
);

// File: tb/test_burst_addr_gen.sv
`timescale 1ns/1ps
module test_burst_addr_gen;
  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic [AW-1:0] ext_addr;
  logic          load_n, cnt_n, rpt_n;
  logic [AW-1:0] addr;
  logic          valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [AW-1:0] m_addr, m_rpt;
  bit            m_valid, m_known;

  always #5 clk = ~clk;

  burst_addr_gen i_burst_addr_gen (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .ext_addr_i (ext_addr),
    .load_ni    (load_n),
    .cnt_en_ni  (cnt_n),
    .rpt_ni     (rpt_n),
    .addr_o     (addr),
    .rpt_valid_o(valid)
  );

  task automatic check_addr(string req, logic [AW-1:0] exp);
    checks++;
    if (addr !== exp) begin
      fails++;
      $display("FAIL %s addr_o actual %h expected %h", req, addr, exp);
    end
  endtask

  task automatic check_valid(string req, logic exp);
    checks++;
    if (valid !== exp) begin
      fails++;
      $display("FAIL %s rpt_valid_o actual %b expected %b", req, valid, exp);
    end
  endtask

  // Called just after a falling edge: drive, apply one rising edge to the model, compare
  task automatic step(logic ld, logic cn, logic rp, logic [AW-1:0] ea);
    string tag;
    load_n = ld; cnt_n = cn; rpt_n = rp; ext_addr = ea;
    @(posedge clk);
    if (!rp) begin
      tag = ld ? "R5" : "R6";
      if (m_valid) m_addr = m_rpt;
      else begin m_known = 1'b0; tag = "R6"; end
    end else if (!ld) begin
      tag = "R2"; m_addr = ea; m_rpt = ea; m_valid = 1'b1; m_known = 1'b1;
    end else if (!cn) begin
      tag = "R3"; m_addr = m_addr + 1'b1;
    end else begin
      tag = "R4";
    end
    @(negedge clk);
    if (m_known) check_addr(tag, m_addr);
    check_valid(m_valid ? "R7" : "R6", m_valid);
  endtask

  task automatic model_reset();
    m_addr = '0; m_valid = 1'b0; m_known = 1'b1; m_rpt = '0;
  endtask

  initial begin
    rst_ni = 1'b0; load_n = 1'b1; cnt_n = 1'b1; rpt_n = 1'b1; ext_addr = '0;
    model_reset();
    repeat (3) @(negedge clk);
    check_addr("R1", '0);
    check_valid("R1", 1'b0);

    // Release with load held low: first two edges ignored (R8)
    load_n = 1'b0; ext_addr = 19'h12345;
    rst_ni = 1'b1;
    @(posedge clk); @(negedge clk);
    check_addr("R8", '0);
    @(posedge clk); @(negedge clk);
    check_addr("R8", '0);
    check_valid("R8", 1'b0);
    step(1'b0, 1'b1, 1'b1, 19'h12345);

    // Counting R3
    repeat (3) step(1'b1, 1'b0, 1'b1, 19'h00000);
    // Wrap R3
    step(1'b0, 1'b1, 1'b1, 19'h7FFFE);
    repeat (3) step(1'b1, 1'b0, 1'b1, 19'h55555);
    // Hold with changing external address R4
    step(1'b1, 1'b1, 1'b1, 19'h2AAAA);
    step(1'b1, 1'b1, 1'b1, 19'h01234);
    // Recall while counting R5
    step(1'b1, 1'b0, 1'b0, 19'h33333);
    // Recall with simultaneous load R6, then count and recall again
    step(1'b0, 1'b1, 1'b0, 19'h00ABC);
    step(1'b1, 1'b0, 1'b1, 19'h00ABC);
    step(1'b1, 1'b1, 1'b0, 19'h00ABC);
    // New load replaces recall address R7
    step(1'b0, 1'b1, 1'b1, 19'h00100);
    step(1'b1, 1'b0, 1'b1, 19'h00000);
    step(1'b1, 1'b1, 1'b0, 19'h00000);

    // Asynchronous reset mid-run R1
    rst_ni = 1'b0;
    #1;
    check_addr("R1", '0);
    check_valid("R1", 1'b0);
    model_reset();
    load_n = 1'b1; cnt_n = 1'b1; rpt_n = 1'b1;
    @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    // Recall before any load: flag must stay clear R6
    step(1'b1, 1'b1, 1'b0, 19'h0);

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      logic rp, ld, cn;
      rp = ($urandom_range(0, 9) != 0);
      ld = ($urandom_range(0, 4) != 0);
      cn = ($urandom_range(0, 1) != 0);
      step(ld, cn, rp, AW'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule